// File: doc/BRIEF.md
# Shared-Port Fetch Stall Controller

This block arbitrates the single memory port of a five-stage in-order pipeline (fetch, decode, execute, memory, write-back) in which instructions and data live in the same single-ported memory. In every cycle it decides which stage owns the port. The fetch stage owns it by default. A valid load or store in the memory stage takes it. The data access always wins.

When the data access wins, the fetch for that cycle cannot happen. The controller holds the program counter and the fetch/decode register, and it marks the decode stage empty for the next cycle so that a bubble travels down the pipe. Instructions already past fetch keep moving. Everything behind the stall slips by exactly one cycle. Two memory instructions that follow each other each cost their own cycle.

The stall decision comes from the execute stage's class, registered one cycle ahead, so the enables come straight from a flop. The address mux select and the port grant decode the memory stage directly. Both views must agree, because the back end never stops.

Top module: `umem_hazard_ctrl`

## Requirements
- R1: After a synchronous active-low reset, with no memory instruction in the memory stage, the outputs are pc_en=1, ifid_en=1, id_bubble=0 and port_data=0, and addr_sel is 2'b01 (bit 0 selects the PC, bit 1 selects the memory-stage address).
- R2: A valid memory-stage instruction of class load (class code 2'b10) gives port_data=1 and addr_sel=2'b10 in the same cycle.
- R3: A valid memory-stage instruction of class store (class code 2'b11) gives port_data=1 and addr_sel=2'b10 in the same cycle.
- R4: The fetch stage keeps the port (port_data=0, addr_sel=2'b01, pc_en=1, ifid_en=1, id_bubble=0) in two cases: the memory-stage instruction has class ALU (2'b00) or branch (2'b01), or the memory stage is not valid, whatever its class field holds.
- R5: In exactly the cycles in which a valid load or store occupies the memory stage, pc_en=0, ifid_en=0 and id_bubble=1.
- R6: Each of two or more consecutive memory instructions causes its own one-cycle fetch stall.
- R7: Stalls delay only instructions not yet fetched. Instruction k is fetched in the first cycle after instruction k-1's fetch that is not a stall cycle, and it reaches write-back four cycles after its fetch.
- R8: A memory instruction present in the execute stage during a reset cycle causes no stall in the first cycle after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ex_vld | input | 1 | Execute stage holds a valid instruction |
| ex_cls | input | 2 | Execute-stage class: 00 ALU, 01 branch, 10 load, 11 store |
| mem_vld | input | 1 | Memory stage holds a valid instruction |
| mem_cls | input | 2 | Memory-stage class, same encoding |
| port_data | output | 1 | 1: the memory port serves the data access; 0: it serves the fetch |
| addr_sel | output | 2 | One-hot address mux select: bit 0 PC, bit 1 memory-stage address |
| pc_en | output | 1 | Program counter may advance |
| ifid_en | output | 1 | Fetch/decode register may load |
| id_bubble | output | 1 | Decode stage receives a NOP in the next cycle |

## Verification
The two functions that collide are the fetch of a new instruction and the data access of a load or store three places ahead. They meet whenever a memory instruction reaches the memory stage while fetch still has work. The bench provokes this by replaying every sequence of six instructions over the four classes, which covers lone loads and stores as well as runs of memory instructions back to back. It drives a pipeline model with the block's enables. Each cycle it checks the port grant and the enables against the occupancy of the memory stage. Afterwards it checks the fetch and write-back cycle of every instruction against a schedule computed by counting the stall cycles that come before its fetch.

// File: rtl/umem_pkg.sv
// Shared types for the shared-port fetch stall controller.
// Assumes two observed stages (execute, memory) and a two-bit class field.
package umem_pkg;
    parameter int CLS_W = 2;

    // Instruction class carried down the pipe with each instruction
    typedef enum logic [CLS_W-1:0] {
        CLS_ALU = 2'd0,
        CLS_BR  = 2'd1,
        CLS_LD  = 2'd2,
        CLS_ST  = 2'd3
    } op_cls_e;

    // Observed stage indices
    localparam int STG_EX  = 0;
    localparam int STG_MEM = 1;
    localparam int N_STG   = 2;

    // Address mux one-hot positions
    localparam int ASEL_PC  = 0;
    localparam int ASEL_MEM = 1;
    localparam int ASEL_N   = 2;
endpackage

// File: rtl/umem_cls_dec.sv
// Per-stage decoder: flags stages that hold a valid load or store.
// Assumes the class field may hold anything when the stage is not valid.
module umem_cls_dec
    import umem_pkg::*;
#(
    parameter int NS = N_STG
) (
    input  logic [NS-1:0]            vld,
    input  logic [NS-1:0][CLS_W-1:0] cls,
    output logic [NS-1:0]            uses_port
);
    // One decoder per observed stage
    for (genvar g = 0; g < NS; g++) begin : g_stage
        assign uses_port[g] = vld[g] && ((cls[g] == CLS_LD) || (cls[g] == CLS_ST));
    end
endmodule

// File: rtl/umem_stall_pred.sv
// Stall predictor: registers the execute stage's port need so that the
// stall is a flop output in the cycle the instruction sits in memory.
// Assumes the back end never stalls, so execute always moves to memory.
module umem_stall_pred (
    input  logic clk,
    input  logic rst_n,
    input  logic ex_uses,
    output logic stall_q
);
    // Capture next cycle's port conflict
    always_ff @(posedge clk) begin
        if (!rst_n) stall_q <= 1'b0;
        else        stall_q <= ex_uses;
    end

    // R5
    stall_follows_ex_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ex_uses |=> stall_q);

    // R4
    no_spurious_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ex_uses |=> !stall_q);
endmodule

// File: rtl/umem_port_arb.sv
// Port arbiter: grants the port to the data access over the fetch and
// produces the PC, fetch/decode and bubble controls from the stall flag.
// Assumes stall and mem_uses describe the same cycle.
module umem_port_arb
    import umem_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mem_uses,
    input  logic              stall,
    output logic              port_data,
    output logic [ASEL_N-1:0] addr_sel,
    output logic              pc_en,
    output logic              ifid_en,
    output logic              id_bubble
);
    // Port grant and address source follow the memory stage
    always_comb begin
        port_data          = mem_uses;
        addr_sel           = '0;
        addr_sel[ASEL_MEM] = mem_uses;
        addr_sel[ASEL_PC]  = !mem_uses;
    end

    // Front-end freeze and bubble follow the registered stall
    always_comb begin
        pc_en     = !stall;
        ifid_en   = !stall;
        id_bubble = stall;
    end

    // R2
    addr_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(addr_sel));

    // R5
    stall_uses_data_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pc_en |-> (addr_sel[ASEL_MEM] && port_data));
endmodule

// File: rtl/umem_hazard_ctrl.sv
// Top of the shared-port fetch stall controller. Decodes the execute and
// memory stage classes, predicts the stall one cycle ahead and arbitrates
// the single memory port. Assumes an in-order pipe with no back-end stall.
module umem_hazard_ctrl
    import umem_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ex_vld,
    input  logic [CLS_W-1:0] ex_cls,
    input  logic             mem_vld,
    input  logic [CLS_W-1:0] mem_cls,
    output logic             port_data,
    output logic [ASEL_N-1:0] addr_sel,
    output logic             pc_en,
    output logic             ifid_en,
    output logic             id_bubble
);
    logic [N_STG-1:0]            stg_vld;
    logic [N_STG-1:0][CLS_W-1:0] stg_cls;
    logic [N_STG-1:0]            stg_uses;
    logic                        stall_q;

    // Gather stage inputs into arrays
    always_comb begin
        stg_vld[STG_EX]  = ex_vld;
        stg_vld[STG_MEM] = mem_vld;
        stg_cls[STG_EX]  = ex_cls;
        stg_cls[STG_MEM] = mem_cls;
    end

    umem_cls_dec #(.NS(N_STG)) u_dec (
        .vld       (stg_vld),
        .cls       (stg_cls),
        .uses_port (stg_uses)
    );

    umem_stall_pred u_pred (
        .clk     (clk),
        .rst_n   (rst_n),
        .ex_uses (stg_uses[STG_EX]),
        .stall_q (stall_q)
    );

    umem_port_arb u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .mem_uses  (stg_uses[STG_MEM]),
        .stall     (stall_q),
        .port_data (port_data),
        .addr_sel  (addr_sel),
        .pc_en     (pc_en),
        .ifid_en   (ifid_en),
        .id_bubble (id_bubble)
    );

    // R5
    pred_matches_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (stall_q == stg_uses[STG_MEM]));
endmodule

// File: tb/umem_hazard_ctrl_tb.sv
// Sweeps every six-instruction class sequence through a pipeline model
// driven by the controller and checks outputs and the fetch/retire schedule.
module umem_hazard_ctrl_tb;
    localparam int N = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ex_vld = 1'b0, mem_vld = 1'b0;
    logic [1:0] ex_cls = 2'd0, mem_cls = 2'd0;
    logic       port_data, pc_en, ifid_en, id_bubble;
    logic [1:0] addr_sel;

    int n_vec = 0, n_bad = 0;
    bit done = 0;

    int prog [N];
    int fcyc [N];
    int wcyc [N];
    int expf [N];

    always #10 clk = ~clk;

    umem_hazard_ctrl u_dut (
        .clk(clk), .rst_n(rst_n),
        .ex_vld(ex_vld), .ex_cls(ex_cls),
        .mem_vld(mem_vld), .mem_cls(mem_cls),
        .port_data(port_data), .addr_sel(addr_sel),
        .pc_en(pc_en), .ifid_en(ifid_en), .id_bubble(id_bubble)
    );

    function automatic bit is_mem(int c);
        return (c == 2) || (c == 3);
    endfunction

    function automatic logic [5:0] exp_out(bit st);
        return {st, (st ? 2'b10 : 2'b01), !st, !st, st};
    endfunction

    task automatic chk(string tag, logic [5:0] act, logic [5:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %b expected %b", tag, act, exp);
        end
    endtask

    task automatic chk_int(string tag, int act, int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic run_seq(int code);
        int  pc, cyc, retired;
        bit  idv, exv, mmv, wbv;
        int  idi, exi, mmi, wbi;
        bit  st;
        for (int i = 0; i < N; i++) begin
            prog[i] = (code >> (2 * i)) & 3;
            wcyc[i] = -1;
            fcyc[i] = -1;
        end
        // arithmetic schedule: skip cycles in which an earlier memory op is in MEM
        for (int k = 0; k < N; k++) begin
            int c;
            bit hit;
            c = (k == 0) ? 0 : expf[k-1] + 1;
            do begin
                hit = 0;
                for (int j = 0; j < k; j++)
                    if (is_mem(prog[j]) && (expf[j] + 3 == c)) hit = 1;
                if (hit) c++;
            end while (hit);
            expf[k] = c;
        end
        // reset, with all stages empty
        rst_n = 1'b0; ex_vld = 0; mem_vld = 0; ex_cls = 2'd2; mem_cls = 2'd3;
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1 reset state", {port_data, addr_sel, pc_en, ifid_en, id_bubble}, exp_out(0));
        pc = 0; cyc = 0; retired = 0;
        idv = 0; exv = 0; mmv = 0; wbv = 0;
        idi = 0; exi = 0; mmi = 0; wbi = 0;
        while (retired < N && cyc < 40) begin
            ex_vld  = exv;
            ex_cls  = exv ? 2'(prog[exi]) : 2'd2;
            mem_vld = mmv;
            mem_cls = mmv ? 2'(prog[mmi]) : 2'd3;
            #1;
            st = mmv && is_mem(prog[mmi]);
            if (mmv && prog[mmi] == 2)
                chk("R2 R5 load in MEM", {port_data, addr_sel, pc_en, ifid_en, id_bubble}, exp_out(1));
            else if (mmv && prog[mmi] == 3)
                chk("R3 R5 store in MEM", {port_data, addr_sel, pc_en, ifid_en, id_bubble}, exp_out(1));
            else
                chk("R4 fetch keeps port", {port_data, addr_sel, pc_en, ifid_en, id_bubble}, exp_out(st));
            if (wbv) begin
                wcyc[wbi] = cyc;
                retired++;
            end
            wbv = mmv; wbi = mmi;
            mmv = exv; mmi = exi;
            exv = idv; exi = idi;
            if (id_bubble) idv = 0;
            else if (ifid_en) begin
                if (pc < N) begin
                    idv = 1; idi = pc; fcyc[pc] = cyc;
                end else idv = 0;
            end
            if (pc_en && pc < N) pc++;
            cyc++;
            @(negedge clk);
        end
        for (int k = 0; k < N; k++) begin
            chk_int($sformatf("R6 R7 fetch cycle seq %0h instr %0d", code, k), fcyc[k], expf[k]);
            chk_int($sformatf("R7 retire cycle seq %0h instr %0d", code, k), wcyc[k], expf[k] + 4);
        end
    endtask

    initial begin
        // R8: memory op in EX during reset must not stall afterwards
        rst_n = 1'b0; ex_vld = 1; ex_cls = 2'd2; mem_vld = 0; mem_cls = 2'd0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1; ex_vld = 0;
        #1;
        chk("R8 no stall after reset", {port_data, addr_sel, pc_en, ifid_en, id_bubble}, exp_out(0));
        @(negedge clk);
        #1;
        chk("R1 idle after reset", {port_data, addr_sel, pc_en, ifid_en, id_bubble}, exp_out(0));
        @(negedge clk);
        for (int code = 0; code < (1 << (2 * N)); code++) run_seq(code);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule